// File: doc/BRIEF.md
# Text Decoder Control Register Bank with Two-Wire Slave

This block is the host-facing control port of a teletext-style text decoder. A host on a two-wire serial bus (I2C) writes a small bank of byte-wide control registers. The same port gives indirect access to an external character page RAM. The block oversamples SCL and SDA with its own system clock and finds start and stop conditions. It takes address and data bytes, drives acknowledge bits and shifts out read data. It never stretches the clock.

After a write address, the first data byte sets an internal register pointer. Every later byte lands at the pointer, and the pointer then moves on by one. Location 11 is the top of the bank and the pointer stays there. A write to location 11 always becomes a page RAM write at the location held in the chapter, row and column registers. A read from location 11 returns either the RAM byte at that location or a status word, chosen by bit 0 of register 0. Each RAM access moves the column on by one and wraps it into the next row. A host can therefore stream a whole row of characters in one bus transaction.

The decoder's display and acquisition logic use registers 0 to 10 as parallel fields. Of these, registers 8, 9 and 10 also form the RAM address: chapter in register 8 bits 2..0, row in register 9 and column in register 10. Register 8 bit 3 is the chapter-clear request and bit 4 the programme-delivery data capture enable. The block only stores these bits and acts on neither.

Top module: `text_ctrl_bank`

## Requirements
- R1: The slave acknowledges only the 7-bit address 11h, which is address byte 22h for a write and 23h for a read. After any other address byte it keeps SDA released until the next start condition.
- R2: On reset, registers 0 to 10 all read 00h except registers 5 and 6, which hold 03h.
- R3: After a write address, the first data byte loads the register pointer; a value above 11 loads 11. Each later byte is stored in the register at the pointer, and the pointer then increments.
- R4: The pointer never goes past 11. A byte written at pointer 11 becomes one RAM write (memWe high for one cycle) at chapter = reg8[2:0], row = reg9[4:0], column = reg10[5:0], whatever the value of reg0 bit 0.
- R5: Each RAM access, read or write, adds one to the column register. Column 39 wraps to 0 and adds one to the row register, and row 25 wraps to 0.
- R6: A read at pointer 11 with reg0 bit 0 = 0 returns the RAM byte at the current location. A read address after a repeated start continues from the pointer left by the write.
- R7: A read at pointer 11 with reg0 bit 0 = 1 returns the status word: bit 0 = syncGood, bit 1 = dataGood, bit 7 = field60 AND syncGood, all other bits 0. Such a read leaves the column and row unchanged.
- R8: A read at pointers 0 to 10 returns 00h and advances the pointer.
- R9: After a read byte that the master does not acknowledge, the slave releases SDA and drives nothing more until the next start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| syncGood | input | 1 | Sync quality flag for the status word |
| dataGood | input | 1 | Text data quality flag for the status word |
| field60 | input | 1 | 60 Hz field rate flag for the status word |
| memRdData | input | 8 | Page RAM read data, valid one cycle after the address |
| memWe | output | 1 | Page RAM write strobe |
| memWdata | output | 8 | Page RAM write data |
| memChapter | output | 3 | Page RAM chapter address |
| memRow | output | 5 | Page RAM row address |
| memCol | output | 6 | Page RAM column address |
| regOut | output | 88 | Registers 0..10 as parallel fields, register n in bits 8n+7..8n |

## Verification
The embedded assertions check on every cycle that the three bus strobes never overlap and that the pointer stays at or below 11. They also check that a start condition always re-arms address reception, that SDA stays released while an address mismatch is being ignored and after a master NACK, and that each RAM write steps or wraps the column. A status read must leave the column untouched. Some behaviours are visible only over whole bus transactions, so the directed scenarios cover them. These are the reset contents, pointer loading and clamping, row and column wrap across a stream of RAM bytes, a repeated start that continues from the written pointer, the masking of the 60 Hz flag by sync quality, and the zero bytes read from write-only locations.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  // Strobes from the bus controller to the register datapath.
  typedef struct packed {
    logic       ptrLoad;  // first byte after a write address
    logic       wrByte;   // later written byte
    logic       rdDone;   // a read byte has been shifted out
    logic [7:0] data;     // received byte
  } busStrb_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WDATA,
    S_WACK,
    S_RDATA,
    S_RACK,
    S_IGNORE
  } busState_t;

endpackage

// File: rtl/tcb_bus_ctrl.sv
module tcb_bus_ctrl
  import tcb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h11,
  parameter int         SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  logic [7:0] rdData,
  output logic     sdaOe,
  output busStrb_t strb
);

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclS, sdaS, sclQ, sdaQ;
  logic sclRise, sclFall, startDet, stopDet;
  busState_t state;
  logic [3:0] bitCnt;
  logic [7:0] rxReg, txReg;
  logic isRead, firstByte, masterAck;

  // input synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclQ  <= 1'b1;
      sdaQ  <= 1'b1;
    end else begin
      sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclQ  <= sclS;
      sdaQ  <= sdaS;
    end
  end

  assign sclS     = sclSh[SYNC_STAGES-1];
  assign sdaS     = sdaSh[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      rxReg     <= '0;
      txReg     <= '0;
      isRead    <= 1'b0;
      firstByte <= 1'b0;
      masterAck <= 1'b0;
      sdaOe     <= 1'b0;
      strb      <= '0;
    end else begin
      strb.ptrLoad <= 1'b0;
      strb.wrByte  <= 1'b0;
      strb.rdDone  <= 1'b0;
      if (startDet) begin
        state  <= S_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          S_ADDR: begin
            if (sclRise) begin
              rxReg  <= {rxReg[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (rxReg[7:1] == DEV_ADDR) begin
                isRead <= rxReg[0];
                sdaOe  <= 1'b1;
                state  <= S_ADDR_ACK;
              end else begin
                state <= S_IGNORE;
              end
            end
          end
          S_ADDR_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                txReg <= rdData;
                sdaOe <= ~rdData[7];
                state <= S_RDATA;
              end else begin
                sdaOe     <= 1'b0;
                firstByte <= 1'b1;
                state     <= S_WDATA;
              end
            end
          end
          S_WDATA: begin
            if (sclRise) begin
              rxReg  <= {rxReg[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              strb.data <= rxReg;
              if (firstByte) strb.ptrLoad <= 1'b1;
              else           strb.wrByte  <= 1'b1;
              sdaOe <= 1'b1;
              state <= S_WACK;
            end
          end
          S_WACK: begin
            if (sclFall) begin
              sdaOe     <= 1'b0;
              bitCnt    <= '0;
              firstByte <= 1'b0;
              state     <= S_WDATA;
            end
          end
          S_RDATA: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe <= 1'b0;
                state <= S_RACK;
              end else begin
                txReg <= {txReg[6:0], 1'b0};
                sdaOe <= ~txReg[6];
              end
            end
          end
          S_RACK: begin
            if (sclRise) begin
              strb.rdDone <= 1'b1;
              masterAck   <= ~sdaS;
            end else if (sclFall) begin
              if (masterAck) begin
                txReg  <= rdData;
                sdaOe  <= ~rdData[7];
                bitCnt <= '0;
                state  <= S_RDATA;
              end else begin
                state <= S_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: a mismatched address keeps the slave silent
  a_r1_ignore_quiet: assert property (@(posedge clk) disable iff (!rstN)
    state == S_IGNORE |-> !sdaOe);

  // R1: every start condition re-arms address reception
  a_r1_start_rearm: assert property (@(posedge clk) disable iff (!rstN)
    $past(startDet) |-> state == S_ADDR);

  // R3: at most one strobe per cycle toward the datapath
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ptrLoad, strb.wrByte, strb.rdDone}));

  // R9: a NACK from the master releases SDA for good
  a_r9_nack_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RACK && sclFall && !masterAck) |=> (!sdaOe && state == S_IGNORE));

endmodule

// File: rtl/tcb_reg_dp.sv
module tcb_reg_dp
  import tcb_pkg::*;
#(
  parameter int NUM_WR_REGS = 11,
  parameter int COLS        = 40,
  parameter int ROWS        = 26,
  parameter int CH_W        = 3,
  parameter int ROW_W       = 5,
  parameter int COL_W       = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  busStrb_t strb,
  input  logic     syncGood,
  input  logic     dataGood,
  input  logic     field60,
  input  logic [7:0] memRdData,
  output logic [7:0] rdData,
  output logic [NUM_WR_REGS-1:0][7:0] regOut,
  output logic     memWe,
  output logic [7:0] memWdata,
  output logic [CH_W-1:0]  memChapter,
  output logic [ROW_W-1:0] memRow,
  output logic [COL_W-1:0] memCol
);

  localparam int PTR_W   = $clog2(NUM_WR_REGS + 1);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(NUM_WR_REGS);
  localparam int CH_IDX  = NUM_WR_REGS - 3;
  localparam int ROW_IDX = NUM_WR_REGS - 2;
  localparam int COL_IDX = NUM_WR_REGS - 1;
  localparam logic [7:0] COL_LAST = 8'(COLS - 1);
  localparam logic [7:0] ROW_LAST = 8'(ROWS - 1);
  localparam logic [7:0] TOP_BYTE = 8'(NUM_WR_REGS);

  logic [NUM_WR_REGS-1:0][7:0] regQ;
  logic [PTR_W-1:0] ptr;
  logic atTop, statusSel, memAccess, colEnd;
  logic [7:0] nextCol, nextRow, statusWord;

  function automatic logic [7:0] rstVal(int idx);
    return (idx == 5 || idx == 6) ? 8'h03 : 8'h00;
  endfunction

  assign atTop      = (ptr == TOP);
  assign statusSel  = regQ[0][0];
  assign memWe      = strb.wrByte & atTop;
  assign memAccess  = memWe | (strb.rdDone & atTop & ~statusSel);
  assign colEnd     = regQ[COL_IDX] >= COL_LAST;
  assign nextCol    = colEnd ? 8'h00 : regQ[COL_IDX] + 8'd1;
  assign nextRow    = (regQ[ROW_IDX] >= ROW_LAST) ? 8'h00 : regQ[ROW_IDX] + 8'd1;
  assign statusWord = {field60 & syncGood, 5'b0, dataGood, syncGood};

  always_comb begin
    if (!atTop)         rdData = 8'h00;
    else if (statusSel) rdData = statusWord;
    else                rdData = memRdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.ptrLoad) begin
      ptr <= (strb.data > TOP_BYTE) ? TOP : strb.data[PTR_W-1:0];
    end else if ((strb.wrByte || strb.rdDone) && !atTop) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WR_REGS; i++) regQ[i] <= rstVal(i);
    end else begin
      for (int i = 0; i < NUM_WR_REGS; i++) begin
        if (strb.wrByte && ptr == PTR_W'(i))
          regQ[i] <= strb.data;
        else if (memAccess && i == COL_IDX)
          regQ[i] <= nextCol;
        else if (memAccess && colEnd && i == ROW_IDX)
          regQ[i] <= nextRow;
      end
    end
  end

  assign regOut     = regQ;
  assign memWdata   = strb.data;
  assign memChapter = regQ[CH_IDX][CH_W-1:0];
  assign memRow     = regQ[ROW_IDX][ROW_W-1:0];
  assign memCol     = regQ[COL_IDX][COL_W-1:0];

  // R4: the pointer stays within the bank
  a_r4_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= TOP);

  // R5: a RAM write below the last column steps the column by one
  a_r5_col_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memWe) && $past(regQ[COL_IDX]) < COL_LAST)
      |-> regQ[COL_IDX] == $past(regQ[COL_IDX]) + 8'd1);

  // R5: a RAM write at the last column wraps it to zero
  a_r5_col_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memWe) && $past(regQ[COL_IDX]) >= COL_LAST) |-> regQ[COL_IDX] == 8'h00);

  // R7: a status read leaves the column alone
  a_r7_status_keeps_col: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.rdDone) && $past(atTop) && $past(statusSel)) |-> $stable(regQ[COL_IDX]));

endmodule

// File: rtl/text_ctrl_bank.sv
module text_ctrl_bank
  import tcb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h11,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_WR_REGS = 11,
  parameter int         COLS        = 40,
  parameter int         ROWS        = 26,
  parameter int         CH_W        = 3,
  parameter int         ROW_W       = 5,
  parameter int         COL_W       = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  input  logic syncGood,
  input  logic dataGood,
  input  logic field60,
  input  logic [7:0] memRdData,
  output logic memWe,
  output logic [7:0] memWdata,
  output logic [CH_W-1:0] memChapter,
  output logic [ROW_W-1:0] memRow,
  output logic [COL_W-1:0] memCol,
  output logic [NUM_WR_REGS-1:0][7:0] regOut
);

  busStrb_t   strb;
  logic [7:0] rdData;

  tcb_bus_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rdData(rdData),
    .sdaOe (sdaOe),
    .strb  (strb)
  );

  tcb_reg_dp #(
    .NUM_WR_REGS(NUM_WR_REGS),
    .COLS       (COLS),
    .ROWS       (ROWS),
    .CH_W       (CH_W),
    .ROW_W      (ROW_W),
    .COL_W      (COL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .syncGood  (syncGood),
    .dataGood  (dataGood),
    .field60   (field60),
    .memRdData (memRdData),
    .rdData    (rdData),
    .regOut    (regOut),
    .memWe     (memWe),
    .memWdata  (memWdata),
    .memChapter(memChapter),
    .memRow    (memRow),
    .memCol    (memCol)
  );

endmodule

// File: tb/text_ctrl_bank_tb.sv
`timescale 1ns/1ps
module text_ctrl_bank_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mLow = 1'b0;
  logic sdaLine;
  logic sdaOe;
  logic syncGood = 1'b0, dataGood = 1'b0, field60 = 1'b0;
  logic [7:0] memRdData;
  logic memWe;
  logic [7:0] memWdata;
  logic [2:0] memChapter;
  logic [4:0] memRow;
  logic [5:0] memCol;
  logic [10:0][7:0] regOut;

  int unsigned total = 0;
  int unsigned bad = 0;
  bit finished = 1'b0;
  logic [7:0] mem [int];

  always #10 clk = ~clk;

  assign sdaLine = ~(mLow | sdaOe);

  text_ctrl_bank u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .syncGood(syncGood), .dataGood(dataGood), .field60(field60),
    .memRdData(memRdData), .memWe(memWe), .memWdata(memWdata),
    .memChapter(memChapter), .memRow(memRow), .memCol(memCol), .regOut(regOut)
  );

  function automatic int key(int ch, int row, int col);
    return (ch << 11) | (row << 6) | col;
  endfunction

  // page RAM model, one-cycle read latency, fresh contents read as 20h
  always @(posedge clk) begin
    if (memWe) mem[key(memChapter, memRow, memCol)] = memWdata;
    memRdData <= mem.exists(key(memChapter, memRow, memCol)) ?
                 mem[key(memChapter, memRow, memCol)] : 8'h20;
  end

  function automatic logic [7:0] memAt(int ch, int row, int col);
    return mem.exists(key(ch, row, col)) ? mem[key(ch, row, col)] : 8'h20;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qd();
    repeat (10) @(negedge clk);
  endtask

  task automatic i2cStart();
    mLow = 1'b0; qd();
    mScl = 1'b1; qd();
    mLow = 1'b1; qd();
    mScl = 1'b0; qd();
  endtask

  task automatic i2cStop();
    mLow = 1'b1; qd();
    mScl = 1'b1; qd();
    mLow = 1'b0; qd();
  endtask

  task automatic i2cWrite(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mLow = ~b[i]; qd();
      mScl = 1'b1; qd(); qd();
      mScl = 1'b0; qd();
    end
    mLow = 1'b0; qd();
    mScl = 1'b1; qd();
    ack = ~sdaLine; qd();
    mScl = 1'b0; qd();
  endtask

  task automatic i2cRead(input logic ackIt, output logic [7:0] b);
    mLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qd();
      mScl = 1'b1; qd();
      b[i] = sdaLine; qd();
      mScl = 1'b0;
    end
    qd();
    mLow = ackIt; qd();
    mScl = 1'b1; qd(); qd();
    mScl = 1'b0; qd();
    mLow = 1'b0;
  endtask

  // start, address 22h, then n bytes; every byte must be acknowledged
  task automatic wrSeq(input string req, input int n, input logic [7:0] d [0:7], input bit doStop);
    logic ack;
    i2cStart();
    i2cWrite(8'h22, ack);
    chk({req, " R1 write address ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      i2cWrite(d[i], ack);
      chk({req, " data ack"}, ack, 1'b1);
    end
    if (doStop) i2cStop();
  endtask

  task automatic tReset();
    for (int i = 0; i < 11; i++)
      chk("R2 reset value", regOut[i], (i == 5 || i == 6) ? 8'h03 : 8'h00);
    chk("R2 SDA released", sdaOe, 1'b0);
  endtask

  task automatic tPtrWrite();
    wrSeq("R3", 4, '{8'h01, 8'hA1, 8'hB2, 8'hC3, 0, 0, 0, 0}, 1'b1);
    chk("R3 reg1", regOut[1], 8'hA1);
    chk("R3 reg2", regOut[2], 8'hB2);
    chk("R3 reg3", regOut[3], 8'hC3);
    chk("R3 reg0 untouched", regOut[0], 8'h00);
    chk("R3 reg4 untouched", regOut[4], 8'h00);
  endtask

  task automatic tBadAddr();
    logic ack;
    i2cStart();
    i2cWrite(8'h44, ack);
    chk("R1 foreign address not acked", ack, 1'b0);
    i2cWrite(8'h02, ack);
    chk("R1 silent after mismatch", ack, 1'b0);
    i2cWrite(8'hFF, ack);
    chk("R1 silent after mismatch", ack, 1'b0);
    i2cStop();
    chk("R1 reg2 unchanged", regOut[2], 8'hB2);
  endtask

  task automatic tMemWrite();
    wrSeq("R4", 7, '{8'h08, 8'h15, 8'd3, 8'd38, 8'h41, 8'h42, 8'h43, 0}, 1'b1);
    chk("R4 reg8 fields", regOut[8], 8'h15);
    chk("R4 mem 5/3/38", memAt(5, 3, 38), 8'h41);
    chk("R5 mem 5/3/39", memAt(5, 3, 39), 8'h42);
    chk("R5 mem 5/4/0 after wrap", memAt(5, 4, 0), 8'h43);
    chk("R5 row after wrap", regOut[9], 8'd4);
    chk("R5 column after wrap", regOut[10], 8'd1);
  endtask

  task automatic tRowWrap();
    wrSeq("R5", 4, '{8'h09, 8'd25, 8'd39, 8'h5A, 0, 0, 0, 0}, 1'b1);
    chk("R5 mem 5/25/39", memAt(5, 25, 39), 8'h5A);
    chk("R5 row 25 wraps", regOut[9], 8'd0);
    chk("R5 column 39 wraps", regOut[10], 8'd0);
  endtask

  task automatic tClamp();
    wrSeq("R3", 2, '{8'h3F, 8'h77, 0, 0, 0, 0, 0, 0}, 1'b1);
    chk("R3 clamped pointer writes RAM", memAt(5, 0, 0), 8'h77);
    chk("R3 clamped pointer steps column", regOut[10], 8'd1);
    chk("R3 clamp left reg0 alone", regOut[0], 8'h00);
  endtask

  task automatic tSelWrite();
    wrSeq("R4", 2, '{8'h00, 8'h01, 0, 0, 0, 0, 0, 0}, 1'b1);
    chk("R4 reg0 select bit", regOut[0], 8'h01);
    wrSeq("R4", 2, '{8'h0B, 8'h66, 0, 0, 0, 0, 0, 0}, 1'b1);
    chk("R4 write at 11 goes to RAM with select=1", memAt(5, 0, 1), 8'h66);
    chk("R4 column after write", regOut[10], 8'd2);
  endtask

  task automatic tStatus();
    logic ack;
    logic [7:0] b;
    syncGood = 1'b1; dataGood = 1'b1; field60 = 1'b1;
    wrSeq("R7", 1, '{8'h0B, 0, 0, 0, 0, 0, 0, 0}, 1'b0);
    i2cStart();
    i2cWrite(8'h23, ack);
    chk("R1 read address ack", ack, 1'b1);
    i2cRead(1'b1, b);
    chk("R7 status all good", b, 8'h83);
    i2cRead(1'b0, b);
    chk("R7 status second byte", b, 8'h83);
    chk("R9 SDA released after NACK", sdaOe, 1'b0);
    i2cStop();
    chk("R7 status read keeps column", regOut[10], 8'd2);
    syncGood = 1'b0;
    i2cStart();
    i2cWrite(8'h23, ack);
    i2cRead(1'b0, b);
    chk("R7 60 Hz flag masked by bad sync", b, 8'h02);
    i2cStop();
  endtask

  task automatic tMemRead();
    logic ack;
    logic [7:0] b;
    wrSeq("R6", 2, '{8'h00, 8'h00, 0, 0, 0, 0, 0, 0}, 1'b1);
    wrSeq("R6", 3, '{8'h09, 8'd3, 8'd38, 0, 0, 0, 0, 0}, 1'b0);
    i2cStart();
    i2cWrite(8'h23, ack);
    chk("R6 read address after repeated start", ack, 1'b1);
    i2cRead(1'b1, b);
    chk("R6 RAM byte 5/3/38", b, 8'h41);
    i2cRead(1'b1, b);
    chk("R6 RAM byte 5/3/39", b, 8'h42);
    i2cRead(1'b0, b);
    chk("R6 RAM byte 5/4/0", b, 8'h43);
    i2cStop();
    chk("R5 row after reads", regOut[9], 8'd4);
    chk("R5 column after reads", regOut[10], 8'd1);
  endtask

  task automatic tWoRead();
    logic ack;
    logic [7:0] b;
    wrSeq("R8", 1, '{8'h03, 0, 0, 0, 0, 0, 0, 0}, 1'b0);
    i2cStart();
    i2cWrite(8'h23, ack);
    for (int i = 3; i < 11; i++) begin
      i2cRead(1'b1, b);
      chk("R8 write-only location reads 00h", b, 8'h00);
    end
    i2cRead(1'b0, b);
    chk("R8 pointer reached 11, fresh RAM byte", b, 8'h20);
    i2cStop();
    chk("R8 column stepped once", regOut[10], 8'd2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tPtrWrite();
    tBadAddr();
    tMemWrite();
    tRowWrap();
    tClamp();
    tSelWrite();
    tStatus();
    tMemRead();
    tWoRead();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule